// File: doc/BRIEF.md
# Register Alias Table with Register File

This block keeps the architectural register values of an out-of-order core together with a rename table that says, for every architectural register, whether its newest value already sits in the register file or will come from an instruction that is still in flight. The issue stage presents two source register indices each cycle. For each source it gets back either a ready flag with the value or the producer tag to wait for. In the same cycle it may redirect one destination register to a new producer tag.

Results come back over one broadcast input carrying a tag and a value. A register whose alias entry still holds that tag takes the value and becomes ready again. A register that was renamed to a newer producer in the meantime ignores the older result. A lookup that meets a matching broadcast in the same cycle sees the broadcast value at once. Lookups always use the mapping from before any rename made in the same cycle, because the issue stage handles one instruction at a time in program order.

Top module: `rat_regfile_top`

## Requirements
- R1: After reset, every one of the 16 registers reads as ready with value 0 on both lookup ports.
- R2: A lookup of a register whose alias entry points at the register file returns ready = 1 and the stored 32-bit value.
- R3: The two lookup ports work independently in the same cycle, each reporting its own register.
- R4: When renEn is high at a clock edge, from the next cycle on a lookup of renIdx returns ready = 0 and tag = renTag.
- R5: When bcEn is high and bcTag equals the pending tag of a register, from the next cycle on that register reads as ready with bcValue.
- R6: A broadcast whose tag no longer matches a register's alias entry leaves both the value and the pending tag of that register unchanged.
- R7: When a lookup hits a pending register while a broadcast with the same tag is present, the lookup returns ready = 1 with bcValue in that same cycle.
- R8: When the same register is looked up and renamed in one cycle, the lookup returns the mapping from before the rename.
- R9: When one register is renamed while a broadcast matches its old tag in the same cycle, the rename wins: the next cycle shows ready = 0 with the new tag.
- R10: With bcEn low, bcTag and bcValue have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcAIdx | input | 4 | Register index for lookup port A |
| srcBIdx | input | 4 | Register index for lookup port B |
| srcAReady | output | 1 | Port A value is available |
| srcATag | output | 4 | Port A producer tag (meaningful when not ready) |
| srcAValue | output | 32 | Port A value (meaningful when ready) |
| srcBReady | output | 1 | Port B value is available |
| srcBTag | output | 4 | Port B producer tag (meaningful when not ready) |
| srcBValue | output | 32 | Port B value (meaningful when ready) |
| renEn | input | 1 | Redirect a destination register this cycle |
| renIdx | input | 4 | Destination register to redirect |
| renTag | input | 4 | Tag of the new producer |
| bcEn | input | 1 | A result is broadcast this cycle |
| bcTag | input | 4 | Tag of the broadcasting producer |
| bcValue | input | 32 | Broadcast result value |

## Verification
The assertions watch every cycle that a rename leaves its register pending on the given tag, that a matching broadcast without a competing rename makes the entry ready, that no register value moves without a write strobe, that at most one entry matches a broadcast, and that a bypassed lookup carries the broadcast value. Only the bench scenarios can show the ordering cases end to end: a stale result arriving after a second rename, a lookup racing a rename of the same register, a rename racing a matching broadcast, and an idle broadcast bus leaving a pending register alone.

// File: rtl/rat_pkg.sv
package rat_pkg;
  parameter int RAT_REGS   = 16;
  parameter int RAT_DATA_W = 32;
  parameter int RAT_TAG_W  = 4;
  localparam int RAT_IDX_W = $clog2(RAT_REGS);

  typedef logic [RAT_IDX_W-1:0]  regIdx_t;
  typedef logic [RAT_TAG_W-1:0]  tag_t;
  typedef logic [RAT_DATA_W-1:0] word_t;

  // Strobes from the alias control to the value datapath
  typedef struct packed {
    logic [RAT_REGS-1:0] wrEn;     // write bcValue into this register
    logic                bypassA;  // port A takes bcValue directly
    logic                bypassB;  // port B takes bcValue directly
  } ratStrobe_t;
endpackage

// File: rtl/rat_alias_ctrl.sv
module rat_alias_ctrl
  import rat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  regIdx_t    srcAIdx,
  input  regIdx_t    srcBIdx,
  input  logic       renEn,
  input  regIdx_t    renIdx,
  input  tag_t       renTag,
  input  logic       bcEn,
  input  tag_t       bcTag,
  output logic       srcAReady,
  output tag_t       srcATag,
  output logic       srcBReady,
  output tag_t       srcBTag,
  output ratStrobe_t strobe
);
  logic [RAT_REGS-1:0] aliasValid;  // 1: value lives in register file
  tag_t                aliasTag [RAT_REGS];
  logic [RAT_REGS-1:0] tagHit;

  // Compare the broadcast tag against every pending entry
  generate
    for (genvar i = 0; i < RAT_REGS; i++) begin : g_match
      assign tagHit[i] = bcEn && !aliasValid[i] && (aliasTag[i] == bcTag);
    end
  endgenerate

  // Lookups read the state from before this cycle's rename
  always_comb begin
    strobe.wrEn    = tagHit;
    strobe.bypassA = tagHit[srcAIdx];
    strobe.bypassB = tagHit[srcBIdx];
    srcAReady      = aliasValid[srcAIdx] | tagHit[srcAIdx];
    srcBReady      = aliasValid[srcBIdx] | tagHit[srcBIdx];
    srcATag        = aliasTag[srcAIdx];
    srcBTag        = aliasTag[srcBIdx];
  end

  // Rename takes priority over a matching broadcast on the same entry
  generate
    for (genvar i = 0; i < RAT_REGS; i++) begin : g_entry
      logic renHere;
      assign renHere = renEn && (renIdx == regIdx_t'(i));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          aliasValid[i] <= 1'b1;
          aliasTag[i]   <= '0;
        end else if (renHere) begin
          aliasValid[i] <= 1'b0;
          aliasTag[i]   <= renTag;
        end else if (tagHit[i]) begin
          aliasValid[i] <= 1'b1;
        end
      end

      AST_BC_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
        tagHit[i] && !renHere |=> aliasValid[i]);  // R5
    end
  endgenerate

  AST_RENAME_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    renEn |=> !aliasValid[$past(renIdx)] && aliasTag[$past(renIdx)] == $past(renTag));  // R4
  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tagHit));  // R6
endmodule

// File: rtl/rat_value_path.sv
module rat_value_path
  import rat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ratStrobe_t strobe,
  input  word_t      bcValue,
  input  regIdx_t    srcAIdx,
  input  regIdx_t    srcBIdx,
  output word_t      srcAValue,
  output word_t      srcBValue
);
  word_t regVal [RAT_REGS];

  generate
    for (genvar i = 0; i < RAT_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN)               regVal[i] <= '0;
        else if (strobe.wrEn[i]) regVal[i] <= bcValue;
      end

      AST_HOLD_UNLESS_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.wrEn[i] |=> $stable(regVal[i]));  // R6
    end
  endgenerate

  always_comb begin
    srcAValue = strobe.bypassA ? bcValue : regVal[srcAIdx];
    srcBValue = strobe.bypassB ? bcValue : regVal[srcBIdx];
  end
endmodule

// File: rtl/rat_regfile_top.sv
module rat_regfile_top
  import rat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [RAT_IDX_W-1:0]  srcAIdx,
  input  logic [RAT_IDX_W-1:0]  srcBIdx,
  output logic                  srcAReady,
  output logic [RAT_TAG_W-1:0]  srcATag,
  output logic [RAT_DATA_W-1:0] srcAValue,
  output logic                  srcBReady,
  output logic [RAT_TAG_W-1:0]  srcBTag,
  output logic [RAT_DATA_W-1:0] srcBValue,
  input  logic                  renEn,
  input  logic [RAT_IDX_W-1:0]  renIdx,
  input  logic [RAT_TAG_W-1:0]  renTag,
  input  logic                  bcEn,
  input  logic [RAT_TAG_W-1:0]  bcTag,
  input  logic [RAT_DATA_W-1:0] bcValue
);
  ratStrobe_t strobe;

  rat_alias_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .renEn(renEn), .renIdx(renIdx), .renTag(renTag),
    .bcEn(bcEn), .bcTag(bcTag),
    .srcAReady(srcAReady), .srcATag(srcATag),
    .srcBReady(srcBReady), .srcBTag(srcBTag),
    .strobe(strobe)
  );

  rat_value_path i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bcValue(bcValue),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .srcAValue(srcAValue), .srcBValue(srcBValue)
  );

  AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bypassA |-> srcAReady && srcAValue == bcValue);  // R7
  AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bypassB |-> srcBReady && srcBValue == bcValue);  // R7
endmodule

// File: tb/test_rat_regfile_top.sv
module test_rat_regfile_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcAIdx = '0, srcBIdx = '0, renIdx = '0, renTag = '0, bcTag = '0;
  logic        renEn = 1'b0, bcEn = 1'b0;
  logic [31:0] bcValue = '0;
  logic        srcAReady, srcBReady;
  logic [3:0]  srcATag, srcBTag;
  logic [31:0] srcAValue, srcBValue;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rat_regfile_top i_rat_regfile_top (
    .clk(clk), .rstN(rstN),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .srcAReady(srcAReady), .srcATag(srcATag), .srcAValue(srcAValue),
    .srcBReady(srcBReady), .srcBTag(srcBTag), .srcBValue(srcBValue),
    .renEn(renEn), .renIdx(renIdx), .renTag(renTag),
    .bcEn(bcEn), .bcTag(bcTag), .bcValue(bcValue)
  );

  // Move to the next drive point: half a cycle after the active edge
  task automatic nextCycle();
    @(negedge clk);
    renEn = 1'b0; bcEn = 1'b0;
  endtask

  task automatic checkA(string req, logic expReady, logic [3:0] expTag, logic [31:0] expVal);
    #2;
    checks++;
    if (srcAReady !== expReady || (expReady && srcAValue !== expVal) || (!expReady && srcATag !== expTag)) begin
      errors++;
      $display("FAIL %s port A: ready=%0b tag=%0d value=%h expected ready=%0b tag=%0d value=%h",
               req, srcAReady, srcATag, srcAValue, expReady, expTag, expVal);
    end
  endtask

  task automatic checkB(string req, logic expReady, logic [3:0] expTag, logic [31:0] expVal);
    #2;
    checks++;
    if (srcBReady !== expReady || (expReady && srcBValue !== expVal) || (!expReady && srcBTag !== expTag)) begin
      errors++;
      $display("FAIL %s port B: ready=%0b tag=%0d value=%h expected ready=%0b tag=%0d value=%h",
               req, srcBReady, srcBTag, srcBValue, expReady, expTag, expVal);
    end
  endtask

  task automatic doRename(logic [3:0] r, logic [3:0] t);
    renEn = 1'b1; renIdx = r; renTag = t;
  endtask

  task automatic doBroadcast(logic [3:0] t, logic [31:0] v);
    bcEn = 1'b1; bcTag = t; bcValue = v;
  endtask

  // R1: reset state on both ports
  task automatic tReset();
    for (int r = 0; r < 16; r++) begin
      srcAIdx = 4'(r); srcBIdx = 4'(15 - r);
      checkA("R1", 1'b1, 4'd0, 32'h0);
      checkB("R1", 1'b1, 4'd0, 32'h0);
    end
  endtask

  // R4, R7, R5, R2, R3: rename, bypass, write back
  task automatic tRenameWrite();
    nextCycle(); doRename(4'd3, 4'd5);
    nextCycle(); srcAIdx = 4'd3; srcBIdx = 4'd4;
    checkA("R4", 1'b0, 4'd5, 32'h0);
    checkB("R3", 1'b1, 4'd0, 32'h0);
    doBroadcast(4'd5, 32'hDEADBEEF);
    checkA("R7", 1'b1, 4'd0, 32'hDEADBEEF);
    nextCycle();
    checkA("R5", 1'b1, 4'd0, 32'hDEADBEEF);
    srcBIdx = 4'd3;
    checkB("R2", 1'b1, 4'd0, 32'hDEADBEEF);
  endtask

  // R6: stale result after a second rename
  task automatic tStale();
    nextCycle(); doRename(4'd6, 4'd1);
    nextCycle(); doRename(4'd6, 4'd2);
    nextCycle(); doBroadcast(4'd1, 32'hBAD0BAD0);
    nextCycle(); srcAIdx = 4'd6;
    checkA("R6", 1'b0, 4'd2, 32'h0);
    doBroadcast(4'd2, 32'h600D600D);
    nextCycle();
    checkA("R6", 1'b1, 4'd0, 32'h600D600D);
  endtask

  // R8: lookup and rename of the same register in one cycle
  task automatic tReadBeforeRename();
    nextCycle(); doRename(4'd7, 4'd3);
    nextCycle(); doBroadcast(4'd3, 32'h00001234);
    nextCycle(); srcAIdx = 4'd7; doRename(4'd7, 4'd4);
    checkA("R8", 1'b1, 4'd0, 32'h00001234);
    nextCycle();
    checkA("R8", 1'b0, 4'd4, 32'h0);
    doBroadcast(4'd4, 32'h00005678);
    nextCycle();
    checkA("R8", 1'b1, 4'd0, 32'h00005678);
  endtask

  // R9: rename racing a matching broadcast
  task automatic tSameCycle();
    nextCycle(); doRename(4'd8, 4'd6);
    nextCycle(); doBroadcast(4'd6, 32'hAAAA5555); doRename(4'd8, 4'd7);
    nextCycle(); srcAIdx = 4'd8;
    checkA("R9", 1'b0, 4'd7, 32'h0);
    doBroadcast(4'd7, 32'h13579BDF);
    nextCycle();
    checkA("R9", 1'b1, 4'd0, 32'h13579BDF);
  endtask

  // R10: idle broadcast bus
  task automatic tIdle();
    nextCycle(); doRename(4'd9, 4'd8);
    nextCycle(); bcTag = 4'd8; bcValue = 32'hFFFF0000; srcAIdx = 4'd9;
    checkA("R10", 1'b0, 4'd8, 32'h0);
    nextCycle();
    checkA("R10", 1'b0, 4'd8, 32'h0);
    srcBIdx = 4'd3;
    checkB("R10", 1'b1, 4'd0, 32'hDEADBEEF);
    doBroadcast(4'd8, 32'h0F0F0F0F);
    nextCycle();
    checkA("R10", 1'b1, 4'd0, 32'h0F0F0F0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tRenameWrite();
    tStale();
    tReadBeforeRename();
    tSameCycle();
    tIdle();
    nextCycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule